// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block passes 18-bit words between two ports, A and B, without inversion. Each direction has its own storage word and three controls: an output enable, a latch enable and a direction clock. While the latch enable is high the storage is transparent and follows its source port. While it is low the storage holds its value. A rising transition of the direction clock reloads it from the source port. The stored word is presented on the far port as a data vector plus an enable flag, so the chip can either build a three-state pad around it or use the pair directly.

Each data input passes through a per-bit keeper register before it reaches the storage. The keeper takes a bit only when that bit is a known 0 or 1. A floating or unknown input therefore leaves the last valid level in place. The direction clocks and latch enables are sampled on the system clock `clk`. A direction-clock edge is the sampled pattern low then high.

Top module: `ubus_xcvr`

## Requirements
- R1: A synchronous reset (rst high at a rising `clk` edge) clears both keepers and both storage words to zero, whatever the data inputs carry.
- R2: While the latch enable of a direction is high, a value applied to its source port appears unchanged on the far port's data output two `clk` edges later. One edge is for the keeper and one is for the storage. All 18 bits pass without inversion.
- R3: While the latch enable is low and the direction clock stays at one level, the far port's data output does not change, however the source port changes.
- R4: With the latch enable low, a direction clock sampled low at one `clk` edge and high at the next loads the keeper's word at that edge. The word is the source value seen one edge earlier, and it appears on the far data output right after that edge.
- R5: With the latch enable low, a falling direction clock and a direction clock held high both leave the storage unchanged.
- R6: A direction-clock rising edge while the latch enable is high changes nothing: the storage stays transparent and keeps following the source.
- R7: When the latch enable goes from high to low, the storage keeps the word it took at the last edge where the enable was still high.
- R8: Each port's enable flag (`b_oe` for A to B, `a_oe` for B to A) equals that direction's output-enable input in the same cycle, with no register in between. The two flags must never be high together.
- R9: The two directions are independent. Controls and data of one direction do not change the other direction's stored word or enable flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Data seen on port A (source for A to B) |
| b_in | input | 18 | Data seen on port B (source for B to A) |
| ab_oe | input | 1 | Output enable toward port B |
| ab_le | input | 1 | Latch enable, A-to-B storage |
| ab_clk | input | 1 | Direction clock, A-to-B storage |
| ba_oe | input | 1 | Output enable toward port A |
| ba_le | input | 1 | Latch enable, B-to-A storage |
| ba_clk | input | 1 | Direction clock, B-to-A storage |
| a_out | output | 18 | Word driven onto port A (B-to-A storage) |
| a_oe | output | 1 | Port A drive flag; low means high impedance |
| b_out | output | 18 | Word driven onto port B (A-to-B storage) |
| b_oe | output | 1 | Port B drive flag; low means high impedance |

## Verification
A storage word loaded at the wrong moment shows up on the far data output at the next `clk` edge after the wrong load. The clearest cases are a capture on a falling or steady direction clock, or a missed capture on a rising one. The bench changes the source port between a load and the check so that such an extra or missing load yields a different word. Holding with new source data applied catches a storage that stays transparent, no later than two edges after the data change. The bench also runs both directions against each other, so a control wired to the wrong direction breaks the other direction's expected word at once.

// File: rtl/ubus_xcvr_pkg.sv
package ubus_xcvr_pkg;

    localparam int unsigned XCVR_WIDTH = 18;
    localparam int unsigned XCVR_DIRS  = 2;
    localparam int unsigned DIR_AB     = 0;
    localparam int unsigned DIR_BA     = 1;

    // controls of one direction, as sampled on the system clock
    typedef struct packed {
        logic oe;
        logic le;
        logic dclk;
    } dir_ctl_t;

    typedef enum logic [1:0] {
        ACT_KEEP    = 2'd0,
        ACT_FOLLOW  = 2'd1,
        ACT_CAPTURE = 2'd2
    } store_act_t;

    // transparency wins over a clock edge; an edge only matters while closed
    function automatic store_act_t pick_act(input logic le, input logic rise);
        if (le)        return ACT_FOLLOW;
        else if (rise) return ACT_CAPTURE;
        else           return ACT_KEEP;
    endfunction

endpackage

// File: rtl/ubus_bus_keeper.sv
module ubus_bus_keeper #(
    parameter int unsigned W = ubus_xcvr_pkg::XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] held
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    held[i] <= 1'b0;
                else if (!$isunknown(din[i]))
                    held[i] <= din[i];
            end
        end
    endgenerate

    // R2: a known input bit is what the keeper holds one edge later
    keep_known_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$isunknown($past(din))) |-> held == $past(din));

endmodule

// File: rtl/ubus_dir_store.sv
module ubus_dir_store
    import ubus_xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dout,
    output logic         dout_en
);

    logic         dclk_q;
    logic         rise;
    store_act_t   act;
    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) dclk_q <= 1'b0;
        else     dclk_q <= ctl.dclk;
    end

    assign rise = ctl.dclk & ~dclk_q;
    assign act  = pick_act(ctl.le, rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            unique case (act)
                ACT_FOLLOW, ACT_CAPTURE: word_q <= src;
                default:                 word_q <= word_q;
            endcase
        end
    end

    assign dout    = word_q;
    assign dout_en = ctl.oe;

    // R2
    follow_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl.le)) |-> word_q == $past(src));

    // R4
    capture_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.le) && $past(ctl.dclk) && !$past(dclk_q))
            |-> word_q == $past(src));

    // R3
    hold_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.le) && ($past(ctl.dclk) == $past(dclk_q)))
            |-> word_q == $past(word_q));

endmodule

// File: rtl/ubus_xcvr.sv
module ubus_xcvr
    import ubus_xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ba_oe,
    input  logic         ba_le,
    input  logic         ba_clk,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    localparam int unsigned NDIR = XCVR_DIRS;

    logic [W-1:0] src_raw  [NDIR];
    logic [W-1:0] src_held [NDIR];
    logic [W-1:0] far_word [NDIR];
    logic         far_en   [NDIR];
    dir_ctl_t     ctl      [NDIR];

    assign src_raw[DIR_AB] = a_in;
    assign src_raw[DIR_BA] = b_in;
    assign ctl[DIR_AB]     = '{oe: ab_oe, le: ab_le, dclk: ab_clk};
    assign ctl[DIR_BA]     = '{oe: ba_oe, le: ba_le, dclk: ba_clk};

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            ubus_bus_keeper #(.W(W)) u_keep (
                .clk  (clk),
                .rst  (rst),
                .din  (src_raw[d]),
                .held (src_held[d])
            );
            ubus_dir_store #(.W(W)) u_store (
                .clk     (clk),
                .rst     (rst),
                .ctl     (ctl[d]),
                .src     (src_held[d]),
                .dout    (far_word[d]),
                .dout_en (far_en[d])
            );
        end
    endgenerate

    assign b_out = far_word[DIR_AB];
    assign b_oe  = far_en[DIR_AB];
    assign a_out = far_word[DIR_BA];
    assign a_oe  = far_en[DIR_BA];

    // R8: both ports driving at once is bus contention
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));

endmodule

// File: tb/tb_ubus_xcvr.sv
module tb_ubus_xcvr;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         ab_oe, ab_le, ab_clk, ba_oe, ba_le, ba_clk;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    always #4 clk = ~clk;

    ubus_xcvr #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe(ba_oe), .ba_le(ba_le), .ba_clk(ba_clk),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] b_exp;
        logic [W-1:0] a_exp;
        logic         b_oe_exp;
        logic         a_oe_exp;
    } exp_item_t;

    exp_item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] m_b, m_a;

    // monitor: compares every queued expectation just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_item_t it;
                it = q.pop_front();
                checks++;
                if (b_out !== it.b_exp || a_out !== it.a_exp ||
                    b_oe !== it.b_oe_exp || a_oe !== it.a_oe_exp) begin
                    fails++;
                    $display("FAIL %s: b_out=%05h a_out=%05h b_oe=%0b a_oe=%0b expected b_out=%05h a_out=%05h b_oe=%0b a_oe=%0b",
                             it.tag, b_out, a_out, b_oe, a_oe,
                             it.b_exp, it.a_exp, it.b_oe_exp, it.a_oe_exp);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag);
        exp_item_t it;
        it.tag = tag; it.b_exp = m_b; it.a_exp = m_a;
        it.b_oe_exp = ab_oe; it.a_oe_exp = ba_oe;
        q.push_back(it);
    endtask

    initial begin
        rst = 1'b1;
        a_in = 18'h3FFFF; b_in = 18'h3FFFF;
        ab_oe = 0; ab_le = 0; ab_clk = 0;
        ba_oe = 0; ba_le = 0; ba_clk = 0;
        m_b = '0; m_a = '0;
        cyc(3);
        rst = 1'b0;
        cyc(2);
        expect_now("R1 reset clears storage");

        // R2 transparent A to B, several patterns
        ab_le = 1;
        a_in = 18'h2AAAA; cyc(2); m_b = 18'h2AAAA; expect_now("R2 follow 2AAAA");
        a_in = 18'h15555; cyc(1); expect_now("R2 not yet after one edge");
        cyc(1); m_b = 18'h15555; expect_now("R2 follow 15555");
        a_in = 18'h3FFFF; cyc(2); m_b = 18'h3FFFF; expect_now("R2 follow all ones");

        // R7 latch closes, R3 holds
        a_in = 18'h12345; cyc(2); m_b = 18'h12345;
        ab_le = 0; a_in = 18'h0F0F0; cyc(3); expect_now("R7 close keeps last open word");
        a_in = 18'h0ABCD; cyc(3); expect_now("R3 hold with new source");
        a_in = 18'h0F0F0; cyc(3); expect_now("R3 hold still");

        // R4 capture on rising direction clock
        ab_clk = 1; cyc(1); m_b = 18'h0F0F0; expect_now("R4 capture on rise");

        // R5 clock high steady, then falling
        a_in = 18'h00FF0; cyc(3); expect_now("R5 clock held high no load");
        ab_clk = 0; cyc(3); expect_now("R5 falling clock no load");
        ab_clk = 1; cyc(1); m_b = 18'h00FF0; expect_now("R4 second capture");
        ab_clk = 0; cyc(1);

        // R6 rising clock while open
        ab_le = 1; a_in = 18'h11111; cyc(2); m_b = 18'h11111; expect_now("R6 open before edge");
        ab_clk = 1; cyc(2); expect_now("R6 edge while open");
        a_in = 18'h22222; cyc(2); m_b = 18'h22222; expect_now("R6 still follows with clock high");
        ab_clk = 0; ab_le = 0; cyc(2);

        // R8 enable flags, one at a time
        ab_oe = 1; #1; expect_now("R8 b_oe follows ab_oe");
        cyc(1); ab_oe = 0; #1; expect_now("R8 b_oe drops");
        cyc(1); ba_oe = 1; #1; expect_now("R8 a_oe follows ba_oe");
        cyc(1); ba_oe = 0;

        // R9 B to A works and leaves A to B alone
        a_in = 18'h3C3C3;
        ba_le = 1; b_in = 18'h1C3A5; cyc(2); m_a = 18'h1C3A5; expect_now("R9 B to A follows, A to B kept");
        ba_le = 0; b_in = 18'h05A5A; cyc(3); expect_now("R9 B to A holds");
        ba_clk = 1; cyc(1); m_a = 18'h05A5A; expect_now("R9 B to A capture");
        ba_clk = 0; ab_clk = 1; cyc(1); m_b = 18'h3C3C3; expect_now("R9 A to B capture leaves B to A");
        ab_clk = 0; cyc(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule